// File: doc/BRIEF.md
# Vector Length Setup Unit

This unit takes the 16-bit length-setup field carried at the front of an instruction group and turns it into new values for the architectural vector length (VL), maximum vector length (MAXVL) and sub-vector length (SUBVL). One cycle of the update strobe applies the field. One cycle later the three state registers hold their new values, a completion pulse appears, and a scalar register write request appears if the field names a nonzero destination.

Bit 15 picks one of two encodings. In the clamped encoding (bit 15 = 0), VL comes from a 5-bit immediate offset by one or from a scalar register. It is then limited to the current MAXVL, and MAXVL is left unchanged. In the direct encoding (bit 15 = 1), a 6-bit immediate offset by one sets MAXVL and VL to the same value. The state stays in force until the next strobe, so it outlives the instruction group that set it. The unit drives the address of a scalar register read port and samples the read data in the strobe cycle.

Top module: `vl_setup_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `vl` = 1, `maxvl` = 1, `subvl` = 1, and `wr_en` and `done` are low.
- R2: When `upd` is high and `blk[15]` = 0 and `blk[0]` = 0, the next `vl` is the smaller of (`blk[5:1]` + 1) and the current `maxvl`, and `maxvl` does not change.
- R3: When `upd` is high and `blk[15]` = 0 and `blk[0]` = 1, the read address `rd_addr` equals `blk[5:1]`. The next `vl` is the smaller of `rd_data` and `maxvl`, compared at the full XLEN width, so any upper bits take part in the comparison. A read value of 0 gives `vl` = 0.
- R4: When `upd` is high and `blk[15]` = 1, the next `maxvl` and the next `vl` both equal `blk[5:0]` + 1, giving a range of 1 to 64.
- R5: On every update the next `subvl` equals `blk[14:13]` + 1, in both encodings.
- R6: In the cycle after an update, if the destination field `blk[12:7]` is nonzero, then `wr_en` is 1, `wr_addr` equals that field, and `wr_data` equals the new `vl` zero-extended. If the field is 0, `wr_en` stays 0 and the state is still updated.
- R7: `vl`, `maxvl` and `subvl` keep their values in every cycle that follows a cycle without `upd`.
- R8: `done` is high for exactly the cycle after each cycle in which `upd` was high, and this holds for back-to-back updates.
- R9: Bit 6 of `blk` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd | input | 1 | Strobe: apply `blk` this cycle |
| blk | input | 16 | Length-setup field |
| rd_addr | output | 5 | Scalar read port address (`blk[5:1]`) |
| rd_data | input | XLEN (64) | Scalar read port data, sampled while `upd` is high |
| vl | output | 7 | Current vector length |
| maxvl | output | 7 | Current maximum vector length |
| subvl | output | 3 | Current sub-vector length (1 to 4) |
| wr_en | output | 1 | Scalar register write request |
| wr_addr | output | 6 | Scalar write destination |
| wr_data | output | XLEN (64) | Scalar write data (the new VL) |
| done | output | 1 | Update completed |

## Verification
Immediates are applied both below and above the current MAXVL, so the test tells a correct clamp apart from a pass-through and from a clamp that always wins. Register-sourced values cover zero, exact equality with MAXVL, small values and a value with only upper bits set beyond 32. That last value exposes any comparison done on truncated bits. Direct-mode fields cover both ends of the 6-bit range, and every SUBVL code is used. Destinations of zero and nonzero, a set reserved bit, back-to-back strobes and idle stretches separate write gating, field masking, pipelining and state retention.

// File: rtl/vlsu_pkg.sv
package vlsu_pkg;
  localparam int BLK_W  = 16;
  localparam int SUB_W  = 2;
  localparam int DEST_W = 6;
  localparam int IMM_W  = 6;
  localparam int SRC_W  = IMM_W - 1;
  localparam int VL_W   = $clog2((1 << IMM_W) + 1);
  localparam int SV_W   = $clog2((1 << SUB_W) + 1);

  typedef struct packed {
    logic              direct;
    logic [SUB_W-1:0]  sub_code;
    logic [DEST_W-1:0] dest;
    logic [IMM_W-1:0]  imm_full;
    logic [SRC_W-1:0]  imm_short;
    logic              from_reg;
  } vlsu_fields_t;
endpackage

// File: rtl/vlsu_decode.sv
module vlsu_decode
  import vlsu_pkg::*;
(
  input  logic [BLK_W-1:0] blk,
  output vlsu_fields_t     fld
);
  localparam int MODE_BIT = BLK_W - 1;
  localparam int SUB_LO   = MODE_BIT - SUB_W;
  localparam int DEST_LO  = SUB_LO - DEST_W;

  always_comb begin
    fld.direct    = blk[MODE_BIT];
    fld.sub_code  = blk[MODE_BIT-1:SUB_LO];
    fld.dest      = blk[SUB_LO-1:DEST_LO];
    fld.imm_full  = blk[IMM_W-1:0];
    fld.imm_short = blk[IMM_W-1:1];
    fld.from_reg  = blk[0];
  end
endmodule

// File: rtl/vlsu_select.sv
module vlsu_select
  import vlsu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  vlsu_fields_t     fld,
  input  logic [VL_W-1:0]  cur_maxvl,
  input  logic [XLEN-1:0]  rd_data,
  output logic [VL_W-1:0]  nxt_vl,
  output logic [VL_W-1:0]  nxt_maxvl,
  output logic [SV_W-1:0]  nxt_subvl
);
  logic [XLEN-1:0] want;
  logic [VL_W-1:0] direct_len;

  always_comb begin
    direct_len = VL_W'(fld.imm_full) + VL_W'(1);
    nxt_subvl  = SV_W'(fld.sub_code) + SV_W'(1);
    if (fld.from_reg) want = rd_data;
    else              want = XLEN'(fld.imm_short) + XLEN'(1);
    if (fld.direct) begin
      nxt_maxvl = direct_len;
      nxt_vl    = direct_len;
    end else begin
      nxt_maxvl = cur_maxvl;
      if (want > XLEN'(cur_maxvl)) nxt_vl = cur_maxvl;
      else                         nxt_vl = want[VL_W-1:0];
    end
  end
endmodule

// File: rtl/vl_setup_unit.sv
module vl_setup_unit
  import vlsu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [BLK_W-1:0]  blk,
  output logic [SRC_W-1:0]  rd_addr,
  input  logic [XLEN-1:0]   rd_data,
  output logic [VL_W-1:0]   vl,
  output logic [VL_W-1:0]   maxvl,
  output logic [SV_W-1:0]   subvl,
  output logic              wr_en,
  output logic [DEST_W-1:0] wr_addr,
  output logic [XLEN-1:0]   wr_data,
  output logic              done
);
  vlsu_fields_t    fld;
  logic [VL_W-1:0] nxt_vl, nxt_maxvl;
  logic [SV_W-1:0] nxt_subvl;

  vlsu_decode u_dec (.blk(blk), .fld(fld));

  vlsu_select #(.XLEN(XLEN)) u_sel (
    .fld(fld), .cur_maxvl(maxvl), .rd_data(rd_data),
    .nxt_vl(nxt_vl), .nxt_maxvl(nxt_maxvl), .nxt_subvl(nxt_subvl)
  );

  assign rd_addr = fld.imm_short;

  always_ff @(posedge clk) begin
    if (rst) begin
      vl      <= VL_W'(1);
      maxvl   <= VL_W'(1);
      subvl   <= SV_W'(1);
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      done    <= 1'b0;
    end else begin
      done  <= upd;
      wr_en <= upd && (fld.dest != '0);
      if (upd) begin
        vl      <= nxt_vl;
        maxvl   <= nxt_maxvl;
        subvl   <= nxt_subvl;
        wr_addr <= fld.dest;
        wr_data <= XLEN'(nxt_vl);
      end
    end
  end
endmodule

// File: rtl/vl_setup_unit_chk.sv
module vl_setup_unit_chk
  import vlsu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              upd,
  input logic [BLK_W-1:0]  blk,
  input logic [VL_W-1:0]   vl,
  input logic [VL_W-1:0]   maxvl,
  input logic [SV_W-1:0]   subvl,
  input logic              wr_en,
  input logic [DEST_W-1:0] wr_addr,
  input logic [XLEN-1:0]   wr_data,
  input logic              done
);
  AST_RESET_STATE: assert property (@(posedge clk) $past(rst) |-> (vl == VL_W'(1) && maxvl == VL_W'(1) && subvl == SV_W'(1) && !wr_en && !done)); // R1
  AST_VL_WITHIN_MAX: assert property (@(posedge clk) disable iff (rst) vl <= maxvl); // R2
  AST_DIRECT_EQUAL: assert property (@(posedge clk) disable iff (rst) ($past(upd) && $past(blk[BLK_W-1]) && !$past(rst)) |-> (vl == maxvl && vl != '0)); // R4
  AST_WRITE_NONZERO: assert property (@(posedge clk) disable iff (rst) wr_en |-> (wr_addr != '0 && wr_data == XLEN'(vl) && done)); // R6
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(upd)) |-> ($stable(vl) && $stable(maxvl) && $stable(subvl))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> (done == $past(upd))); // R8
endmodule

bind vl_setup_unit vl_setup_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .upd(upd), .blk(blk), .vl(vl), .maxvl(maxvl),
  .subvl(subvl), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .done(done)
);

// File: tb/tb_vl_setup_unit.sv
`timescale 1ns/1ps
module tb_vl_setup_unit;
  localparam int XLEN = 64;

  logic            clk = 0;
  logic            rst = 1;
  logic            upd = 0;
  logic [15:0]     blk = '0;
  logic [4:0]      rd_addr;
  logic [XLEN-1:0] rd_data = '0;
  logic [6:0]      vl, maxvl;
  logic [2:0]      subvl;
  logic            wr_en, done;
  logic [5:0]      wr_addr;
  logic [XLEN-1:0] wr_data;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int        e_vl;
    int        e_maxvl;
    int        e_subvl;
    bit        e_wr;
    int        e_addr;
    string     tag;
  } exp_t;
  exp_t sb[$];

  int m_vl = 1, m_maxvl = 1, m_subvl = 1;

  always #2 clk = ~clk;

  vl_setup_unit #(.XLEN(XLEN)) dut (
    .clk(clk), .rst(rst), .upd(upd), .blk(blk), .rd_addr(rd_addr),
    .rd_data(rd_data), .vl(vl), .maxvl(maxvl), .subvl(subvl),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(string tag, bit direct, int sub, int dest, int len,
                       bit from_reg, bit rsv, logic [XLEN-1:0] rval, bit hold);
    exp_t e;
    longint want;
    blk = {direct, 2'(sub), 6'(dest), rsv,
           direct ? 6'(len) : {5'(len), from_reg}};
    rd_data = rval;
    upd = 1;
    if (!direct && from_reg) begin
      #1 chk({tag, " R3 rd_addr"}, rd_addr, len);
    end
    if (direct) begin
      m_maxvl = len + 1;
      m_vl = len + 1;
    end else begin
      if (from_reg) want = (rval > XLEN'(m_maxvl)) ? m_maxvl : longint'(rval);
      else          want = len + 1;
      m_vl = (want > m_maxvl) ? m_maxvl : int'(want);
    end
    m_subvl = sub + 1;
    e.e_vl = m_vl; e.e_maxvl = m_maxvl; e.e_subvl = m_subvl;
    e.e_wr = (dest != 0); e.e_addr = dest; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    if (!hold) upd = 0;
  endtask

  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 done without update: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " vl"}, vl, e.e_vl);
        chk({e.tag, " maxvl"}, maxvl, e.e_maxvl);
        chk({e.tag, " R5 subvl"}, subvl, e.e_subvl);
        chk({e.tag, " R6 wr_en"}, wr_en, e.e_wr);
        if (e.e_wr) begin
          chk({e.tag, " R6 wr_addr"}, wr_addr, e.e_addr);
          chk({e.tag, " R6 wr_data"}, wr_data, e.e_vl);
        end
      end
    end
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset vl", vl, 1);
    chk("R1 reset maxvl", maxvl, 1);
    chk("R1 reset subvl", subvl, 1);
    chk("R1 reset wr_en", wr_en, 0);
    chk("R1 reset done", done, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset vl", vl, 1);

    apply("R4 direct 40", 1, 1, 3, 39, 0, 0, '0, 0);
    apply("R2 imm below max", 0, 0, 5, 9, 0, 0, '0, 0);
    apply("R2 imm 32", 0, 3, 0, 31, 0, 0, '0, 0);
    apply("R4 direct 6", 1, 2, 7, 5, 0, 0, '0, 0);
    apply("R2 imm clamped", 0, 0, 9, 31, 0, 0, '0, 0);
    apply("R3 reg small", 0, 1, 11, 4, 1, 0, 64'd4, 0);
    apply("R3 reg zero", 0, 0, 12, 17, 1, 0, 64'd0, 0);
    apply("R3 reg upper bits", 0, 0, 13, 30, 1, 0, 64'h1_0000_0003, 0);
    apply("R3 reg large", 0, 2, 0, 1, 1, 0, 64'd100, 0);
    apply("R6 dest zero", 0, 0, 0, 2, 0, 0, '0, 0);
    apply("R4 direct 64", 1, 3, 63, 63, 0, 0, '0, 0);
    apply("R3 reg equal max", 0, 0, 21, 8, 1, 0, 64'd64, 0);
    apply("R9 reserved bit", 0, 1, 22, 19, 0, 1, '0, 0);
    apply("R4 direct 1", 1, 0, 1, 0, 0, 1, '0, 0);
    apply("R2 imm one", 0, 0, 2, 0, 0, 0, '0, 0);
    apply("R8 back-to-back a", 1, 1, 4, 15, 0, 0, '0, 1);
    apply("R8 back-to-back b", 0, 2, 6, 3, 0, 0, '0, 0);
    repeat (2) @(negedge clk);
    chk("R8 queue drained", sb.size(), 0);
    repeat (5) @(negedge clk);
    chk("R7 hold vl", vl, m_vl);
    chk("R7 hold maxvl", maxvl, m_maxvl);
    chk("R7 hold subvl", subvl, m_subvl);
    chk("R8 idle done", done, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule